// File: doc/BRIEF.md
# Self-Timed Fall-Through Word Chain

This block is the middle storage of a first-in first-out buffer. It is a chain of word-wide locations, each with its own occupied flag. A word written into the top location moves toward the bottom on its own. It advances one location per clock and waits only while the location below it is still held. The input stage sees a top-empty flag and a write port. The output stage sees a bottom-valid flag, the bottom word and a read acknowledge.

The chain depth defaults to 62 words of 4 bits. A surrounding design that adds one input register and one output register reaches 64 words in total. Moves are made in whole clock cycles. A location may accept the word above it when it is empty, or when its own word leaves in the same cycle. Because of this, one acknowledge at the bottom of a full chain shifts the whole column down at once.

Reset clears the occupied flags only. The stored data bits keep their values. While reset is high, no word moves.

Top module: `fts_stack`

## Requirements
- R1: While reset is high and in the first cycle after it, top_empty is 1 and bot_valid is 0.
- R2: Reset does not alter stored data: bot_data keeps its value across a reset.
- R3: A write (wr_en=1) is accepted only in a cycle where top_empty is 1. A write offered while top_empty is 0 is dropped. Without an accepted write, top_empty cannot go from 1 to 0.
- R4: A word written into an empty chain shows bot_valid=1 with that word on bot_data exactly DEPTH clock edges after the edge that wrote it, counting the write edge. bot_valid stays 0 one edge earlier.
- R5: While bot_valid is 1 and rd_ack is 0, bot_valid stays 1 and bot_data stays unchanged.
- R6: With no acknowledges, the chain accepts exactly DEPTH words and then holds top_empty at 0.
- R7: Words leave at the bottom (rd_ack=1 while bot_valid=1) in exactly the order they were accepted. No word is lost or repeated, including when a write and a read fall in the same cycle.
- R8: rd_ack while bot_valid is 0 has no effect: an empty chain stays empty.
- R9: When the chain is full, one acknowledge moves every word down in that same edge. Afterwards top_empty is 1, bot_valid is 1, and bot_data shows the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the occupied flags |
| wr_en | input | 1 | Offer wr_data to the top location |
| wr_data | input | WIDTH | Word offered at the top |
| top_empty | output | 1 | Top location is free; a write is taken this cycle |
| bot_valid | output | 1 | Bottom location holds a word |
| bot_data | output | WIDTH | Word held in the bottom location |
| rd_ack | input | 1 | Output stage takes the bottom word |

## Verification
Two actions can fall on the same edge: a write entering at the top and a word leaving at the bottom. When the chain is full, the leaving word also has to ripple a free slot up the entire column. The bench provokes the overlap in two ways. It sweeps every pairing of four write rates with four acknowledge rates, and it separately acknowledges a full chain while the top is blocked. A queue model filled from the ports judges every word that leaves against the accepted order. The bench also counts accepted words against the depth.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // per-location movement decision for one clock cycle
  typedef struct packed {
    logic take;   // location loads the word from above (or the write port)
    logic leave;  // location's current word moves on this cycle
  } move_t;
endpackage

// File: rtl/fts_advance.sv
module fts_advance #(
  parameter int DEPTH = 62
) (
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_ack,
  input  logic [DEPTH-1:0]   occ,
  output fts_pkg::move_t     mv [DEPTH]
);
  localparam int LAST = DEPTH - 1;

  // The leave decision ripples upward from the bottom: a word may move when
  // the location below is empty or is itself emptying in the same cycle.
  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    logic lv;
    logic tk;
    if (i == LAST) begin : g_bot
      assign lv = occ[i] & rd_ack & ~rst;
    end else begin : g_mid
      assign lv = occ[i] & ~rst & (~occ[i+1] | g_loc[i+1].lv);
    end
    if (i == 0) begin : g_top
      // write port takes only a truly empty top location
      assign tk = wr_en & ~occ[0] & ~rst;
    end else begin : g_body
      assign tk = occ[i-1] & ~rst & (~occ[i] | lv);
    end
    assign mv[i] = '{take: tk, leave: lv};
  end
endmodule

// File: rtl/fts_cell.sv
module fts_cell #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  fts_pkg::move_t   mv,
  input  logic [WIDTH-1:0] din,
  output logic             occ,
  output logic [WIDTH-1:0] dout
);
  // occupancy is the only reset state
  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= 1'b0;
    end else begin
      occ <= mv.take | (occ & ~mv.leave);
    end
  end

  // data bits carry no reset and load only on a take
  always_ff @(posedge clk) begin
    if (mv.take) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/fts_stack.sv
module fts_stack #(
  parameter int DEPTH = 62,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             top_empty,
  output logic             bot_valid,
  output logic [WIDTH-1:0] bot_data,
  input  logic             rd_ack
);
  localparam int LAST = DEPTH - 1;

  if (DEPTH < 2) begin : g_bad_depth
    $error("fts_stack: DEPTH must be at least 2");
  end

  logic [DEPTH-1:0] occ;
  logic [WIDTH-1:0] word_q [DEPTH];
  fts_pkg::move_t   mv [DEPTH];

  fts_advance #(.DEPTH(DEPTH)) u_adv (
    .rst    (rst),
    .wr_en  (wr_en),
    .rd_ack (rd_ack),
    .occ    (occ),
    .mv     (mv)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_chain
    logic [WIDTH-1:0] src;
    if (i == 0) begin : g_src_top
      assign src = wr_data;
    end else begin : g_src_above
      assign src = word_q[i-1];
    end
    fts_cell #(.WIDTH(WIDTH)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .mv   (mv[i]),
      .din  (src),
      .occ  (occ[i]),
      .dout (word_q[i])
    );
  end

  assign top_empty = ~occ[0];
  assign bot_valid = occ[LAST];
  assign bot_data  = word_q[LAST];
endmodule

// File: rtl/fts_stack_chk.sv
module fts_stack_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_ack,
  input logic             top_empty,
  input logic             bot_valid,
  input logic [WIDTH-1:0] bot_data
);
  logic             rst_q = 1'b0;
  logic [WIDTH-1:0] bd_q  = '0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    bd_q  <= bot_data;
  end

  always @(posedge clk) begin
    // R1
    if (rst_q && !rst) begin
      r1_reset_state_chk: assert (top_empty && !bot_valid)
        else $error("R1 reset state wrong");
    end
    // R2
    if (rst_q && rst) begin
      r2_data_kept_chk: assert (bot_data === bd_q)
        else $error("R2 data changed in reset");
    end
  end

  // R3
  r3_no_spurious_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (top_empty && !wr_en) |=> top_empty);

  // R5
  r5_hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (bot_valid && !rd_ack) |=> bot_valid);

  // R5
  r5_hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (bot_valid && !rd_ack) |=> $stable(bot_data));
endmodule

bind fts_stack fts_stack_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_ack    (rd_ack),
  .top_empty (top_empty),
  .bot_valid (bot_valid),
  .bot_data  (bot_data)
);

// File: tb/sim_fts_stack.sv
`timescale 1ns/1ps
module sim_fts_stack;
  localparam int D = 5;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_ack = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         top_empty;
  logic         bot_valid;
  logic [W-1:0] bot_data;

  fts_stack #(.DEPTH(D), .WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .top_empty(top_empty), .bot_valid(bot_valid), .bot_data(bot_data),
    .rd_ack(rd_ack)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] q[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model update at the falling edge, then advance one rising edge
  task automatic cyc();
    @(negedge clk);
    if (!rst && wr_en && top_empty) q.push_back(wr_data);
    if (!rst && rd_ack && bot_valid) begin
      if (q.size() == 0) chk(1'b0, "R7 word from empty model", bot_data, 0);
      else begin
        chk(bot_data == q[0], "R7 order", bot_data, q[0]);
        void'(q.pop_front());
      end
    end
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int acc;
    repeat (3) cyc();
    // R1
    chk(top_empty == 1'b1, "R1 top_empty in reset", top_empty, 1);
    chk(bot_valid == 1'b0, "R1 bot_valid in reset", bot_valid, 0);
    rst = 1'b0;
    cyc();
    chk(top_empty == 1'b1 && bot_valid == 1'b0, "R1 after release", bot_valid, 0);

    // R4 latency through an empty chain
    wr_en = 1'b1; wr_data = 4'hA;
    cyc();
    wr_en = 1'b0;
    repeat (D-2) cyc();
    chk(bot_valid == 1'b0, "R4 too early", bot_valid, 0);
    cyc();
    chk(bot_valid == 1'b1, "R4 arrival", bot_valid, 1);
    chk(bot_data == 4'hA, "R4 data", bot_data, 4'hA);

    // R5 hold without acknowledge
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk(bot_valid && bot_data == 4'hA, "R5 hold", bot_data, 4'hA);
    end

    // R2 reset keeps data, clears flags
    rst = 1'b1;
    cyc(); cyc();
    chk(bot_data == 4'hA, "R2 data kept", bot_data, 4'hA);
    chk(bot_valid == 1'b0, "R1 flags cleared", bot_valid, 0);
    rst = 1'b0;
    q.delete();
    cyc();
    chk(top_empty == 1'b1, "R1 top free after reset", top_empty, 1);

    // R6 fill without reads
    acc = 0;
    wr_en = 1'b1;
    for (int c = 0; c < 4*D; c++) begin
      wr_data = W'(c + 1);
      if (top_empty) acc++;
      cyc();
    end
    wr_en = 1'b0;
    chk(acc == D, "R6 accepted count", acc, D);
    chk(top_empty == 1'b0, "R6 top held", top_empty, 0);
    chk(q.size() == D, "R6 model count", q.size(), D);

    // R9 one acknowledge shifts the whole full chain
    rd_ack = 1'b1;
    cyc();
    rd_ack = 1'b0;
    chk(top_empty == 1'b1, "R9 top freed", top_empty, 1);
    chk(bot_valid == 1'b1, "R9 bottom refilled", bot_valid, 1);
    chk(bot_data == q[0], "R9 next word", bot_data, q[0]);

    // R3 write offered while top is held is dropped
    wr_en = 1'b1; wr_data = 4'hC;
    cyc();
    wr_data = 4'hF;
    chk(top_empty == 1'b0, "R3 top held before blocked write", top_empty, 0);
    cyc();
    wr_en = 1'b0;
    chk(q.size() == D, "R3 blocked write dropped", q.size(), D);

    // R8 drain and keep acknowledging an empty chain
    rd_ack = 1'b1;
    repeat (3*D) cyc();
    chk(q.size() == 0, "R7 all words out", q.size(), 0);
    repeat (2) cyc();
    chk(bot_valid == 1'b0, "R8 ack on empty", bot_valid, 0);
    chk(top_empty == 1'b1, "R8 top stays free", top_empty, 1);
    rd_ack = 1'b0;

    // R7 sweep of write and read rates, overlapping in the same cycles
    for (int w = 0; w < 4; w++) begin
      for (int r = 0; r < 4; r++) begin
        for (int c = 0; c < 300; c++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          wr_en   = (lfsr[1:0] <= 2'(w));
          wr_data = lfsr[7:4];
          rd_ack  = (lfsr[9:8] <= 2'(r));
          cyc();
        end
        wr_en = 1'b0;
        rd_ack = 1'b1;
        repeat (3*D) cyc();
        rd_ack = 1'b0;
        chk(q.size() == 0, "R7 no loss after pattern", q.size(), 0);
        chk(bot_valid == 1'b0, "R7 no extra word", bot_valid, 0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule